// File: doc/BRIEF.md
# Interrupt Stack Switch Validator

This block prepares the stack switch for an interrupt that enters a more privileged code level. Given the privilege level of the target code segment, the size and limit of the current task state area, the gate size and whether an error code will be pushed, it works out where the new stack pointer and selector sit in the task state area. It fetches both, fetches the stack descriptor, and runs the protection checks in a fixed order.

It returns either the new stack selector and pointer, or the first fault found, with a fault class and a 16-bit error code. Memory is reached through a plain request/response port that may stall for any number of cycles. Pushing the frame and loading segment registers are left to the caller.

Top module: `istk_switch_validator`

## Requirements
- R1: With a 32-bit task state area (`tss32`=1) the pointer is fetched from offset tgt_dpl*8+4 and then the selector from that offset plus 4, both in memory space 0 (task state area).
- R2: With a 16-bit task state area the pointer is fetched from offset tgt_dpl*4+2 and the selector from that offset plus 2; only bits 15:0 of the pointer response are used, zero-extended.
- R3: If the pointer offset plus 7 (32-bit area) or plus 4 (16-bit area) exceeds `tss_limit`, fault class 1 is reported with error code {tss_sel[15:2], 0, ext_evt} and no memory fetch is made.
- R4: A stack selector with bits 15:2 all zero gives fault class 1 with error code {15'b0, ext_evt}.
- R5: Fault class 1 with error code {sel[15:2], 0, ext_evt} is reported when sel | 7 exceeds the table limit (`ldt_limit` when sel bit 2 is set, else `gdt_limit`), or when sel bits 1:0 differ from `tgt_dpl`.
- R6: Fault class 1 with the selector error code is reported when descriptor bits 46:45 differ from `tgt_dpl`, or when the descriptor is not a writable data segment (bit 44 = 1, bit 43 = 0, bit 41 = 1).
- R7: A descriptor with present bit 47 clear gives fault class 2 with the selector error code.
- R8: Required room is 24 or 20 bytes (32-bit gate, with or without error code) and 12 or 10 bytes (16-bit gate). With limit = {desc[51:48], desc[15:0]}, scaled to limit*4096+4095 when bit 55 is set, room exists only if pointer >= room and pointer-1 <= limit; otherwise fault class 2 with the selector error code.
- R9: If every stack check passes and `entry_ip` > `cs_limit`, fault class 3 with error code 0 is reported.
- R10: Checks are ranked R3, R4, R5, R6 (privilege then type), R7, R8, R9; only the first failure is reported.
- R11: With no fault, class 0 and error code 0 are reported with `new_ss` = selector and `new_sp` = pointer; on any fault both are zero.
- R12: `done` is high for exactly one cycle per request; `busy` is high from the cycle after `start` up to and including the `done` cycle; `start` while busy is ignored.
- R13: `mem_req` is held with stable `mem_space` and `mem_addr` until `mem_valid`; the descriptor fetch uses space 1 (global table) or 2 (local table, selector bit 2 set) at address sel with bits 2:0 cleared.
- R14: Bit 0 of every class 1 and class 2 error code equals `ext_evt` captured at `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a validation; request inputs captured |
| tgt_dpl | input | 2 | Privilege level of the target code segment |
| tss32 | input | 1 | Task state area is 32-bit |
| tss_limit | input | AW | Limit of the task state area |
| tss_sel | input | 16 | Selector of the current task state area |
| gate32 | input | 1 | Gate is 32-bit |
| push_err | input | 1 | An error code will be pushed |
| ext_evt | input | 1 | Event is external, copied to error code bit 0 |
| gdt_limit | input | AW | Global descriptor table limit |
| ldt_limit | input | AW | Local descriptor table limit |
| cs_limit | input | AW | Target code segment limit |
| entry_ip | input | AW | Entry instruction pointer |
| mem_req | output | 1 | Fetch request |
| mem_space | output | 2 | 0 task state area, 1 global table, 2 local table |
| mem_addr | output | AW | Byte offset within the space |
| mem_valid | input | 1 | Fetch response valid |
| mem_rdata | input | 64 | Fetch response data |
| busy | output | 1 | Validation in progress |
| done | output | 1 | Result valid for one cycle |
| fault_cls | output | 2 | 0 none, 1 invalid task state, 2 stack, 3 general protection |
| err_code | output | 16 | Error code of the fault |
| new_ss | output | 16 | New stack selector |
| new_sp | output | AW | New stack pointer |

## Verification
Each check is driven into failure alone and then paired with a later check that also fails, so a wrong ranking shows as the wrong class or error code. Offsets are tried at privilege levels 0 through 3 with both task state sizes, with limits set exactly at and one below the last byte, which separates the 7 and 4 byte reaches. Stack room is probed one byte either side of each of the four sizes and at both ends of a byte-granular and a page-scaled limit. Variable memory latency and a repeated start in flight show that the fetch port holds and the captured request is not disturbed.

// File: rtl/isv_pkg.sv
package isv_pkg;
   localparam int SEL_W  = 16;
   localparam int DESC_W = 64;

   typedef enum logic [1:0] {
      FC_NONE  = 2'd0,
      FC_TASK  = 2'd1,
      FC_STACK = 2'd2,
      FC_PROT  = 2'd3
   } fault_e;

   typedef enum logic [1:0] {
      SP_TSS = 2'd0,
      SP_GDT = 2'd1,
      SP_LDT = 2'd2
   } space_e;

   typedef struct packed {
      fault_e            cls;
      logic [SEL_W-1:0]  err;
   } fault_t;
endpackage

// File: rtl/isv_tss_locate.sv
module isv_tss_locate #(
   parameter int AW = 32
) (
   input  logic [1:0]    dpl_i,
   input  logic          tss32_i,
   input  logic [AW-1:0] limit_i,
   output logic [AW-1:0] ptr_off_o,
   output logic [AW-1:0] sel_off_o,
   output logic          over_o
);
   localparam int REACH32 = 7;
   localparam int REACH16 = 4;

   logic [AW-1:0] last_byte;

   // 32-bit area: dpl*8+4; 16-bit area: dpl*4+2
   assign ptr_off_o = tss32_i ? AW'({dpl_i, 3'b100}) : AW'({dpl_i, 2'b10});
   assign sel_off_o = ptr_off_o + (tss32_i ? AW'(4) : AW'(2));
   assign last_byte = ptr_off_o + (tss32_i ? AW'(REACH32) : AW'(REACH16));
   assign over_o    = last_byte > limit_i;
endmodule

// File: rtl/isv_sel_check.sv
module isv_sel_check import isv_pkg::*; #(
   parameter int AW = 32
) (
   input  logic [SEL_W-1:0] sel_i,
   input  logic [1:0]       code_dpl_i,
   input  logic [AW-1:0]    gdt_limit_i,
   input  logic [AW-1:0]    ldt_limit_i,
   input  logic             ext_i,
   output fault_t           flt_o
);
   logic [AW-1:0] tab_limit;
   logic [AW-1:0] sel_end;

   assign tab_limit = sel_i[2] ? ldt_limit_i : gdt_limit_i;
   assign sel_end   = AW'({sel_i[SEL_W-1:3], 3'b111});

   always_comb begin
      flt_o = '{cls: FC_NONE, err: '0};
      if (sel_i[SEL_W-1:2] == '0)
         flt_o = '{cls: FC_TASK, err: {{(SEL_W-1){1'b0}}, ext_i}};
      else if ((sel_end > tab_limit) || (sel_i[1:0] != code_dpl_i))
         flt_o = '{cls: FC_TASK, err: {sel_i[SEL_W-1:2], 1'b0, ext_i}};
   end
endmodule

// File: rtl/isv_stack_check.sv
module isv_stack_check import isv_pkg::*; #(
   parameter int AW      = 32,
   parameter bit GRAN_EN = 1'b1
) (
   input  logic [DESC_W-1:0] desc_i,
   input  logic [SEL_W-1:0]  sel_i,
   input  logic [1:0]        code_dpl_i,
   input  logic [AW-1:0]     sp_i,
   input  logic              gate32_i,
   input  logic              push_err_i,
   input  logic              ext_i,
   output fault_t            flt_o
);
   localparam int LIM_W = 32;

   logic [19:0]      lim_raw;
   logic [LIM_W-1:0] lim_eff;
   logic [4:0]       room;
   logic             data_wr;
   logic             room_ok;
   logic [SEL_W-1:0] sel_err;
   logic             desc_unused;

   assign lim_raw = {desc_i[51:48], desc_i[15:0]};

   if (GRAN_EN) begin : g_gran
      assign lim_eff = desc_i[55] ? {lim_raw, 12'hFFF} : {12'h000, lim_raw};
   end else begin : g_flat
      assign lim_eff = {12'h000, lim_raw};
   end

   assign desc_unused = ^{desc_i[39:16], desc_i[42], desc_i[40], desc_i[63:52]};

   assign room    = gate32_i ? (push_err_i ? 5'd24 : 5'd20)
                             : (push_err_i ? 5'd12 : 5'd10);
   assign data_wr = desc_i[44] & ~desc_i[43] & desc_i[41];
   assign room_ok = (sp_i >= AW'(room)) && ((sp_i - AW'(1)) <= AW'(lim_eff));
   assign sel_err = {sel_i[SEL_W-1:2], 1'b0, ext_i};

   always_comb begin
      flt_o = '{cls: FC_NONE, err: '0};
      if ((desc_i[46:45] != code_dpl_i) || !data_wr)
         flt_o = '{cls: FC_TASK, err: sel_err};
      else if (!desc_i[47] || !room_ok)
         flt_o = '{cls: FC_STACK, err: sel_err};
   end
endmodule

// File: rtl/istk_switch_validator.sv
module istk_switch_validator import isv_pkg::*; #(
   parameter int AW      = 32,
   parameter bit GRAN_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        tgt_dpl,
   input  logic              tss32,
   input  logic [AW-1:0]     tss_limit,
   input  logic [15:0]       tss_sel,
   input  logic              gate32,
   input  logic              push_err,
   input  logic              ext_evt,
   input  logic [AW-1:0]     gdt_limit,
   input  logic [AW-1:0]     ldt_limit,
   input  logic [AW-1:0]     cs_limit,
   input  logic [AW-1:0]     entry_ip,
   output logic              mem_req,
   output logic [1:0]        mem_space,
   output logic [AW-1:0]     mem_addr,
   input  logic              mem_valid,
   input  logic [63:0]       mem_rdata,
   output logic              busy,
   output logic              done,
   output logic [1:0]        fault_cls,
   output logic [15:0]       err_code,
   output logic [15:0]       new_ss,
   output logic [AW-1:0]     new_sp
);
   if (AW < 32) begin : g_bad_aw
      $error("istk_switch_validator: AW must be at least 32");
   end

   typedef enum logic [2:0] {
      ST_IDLE, ST_LOC, ST_PTR, ST_SEL, ST_DESC, ST_DONE
   } state_e;

   state_e           state;
   logic [1:0]       dpl_q;
   logic             tss32_q, gate32_q, perr_q, ext_q;
   logic [AW-1:0]    tlim_q, glim_q, llim_q, cslim_q, ip_q, sp_q;
   logic [SEL_W-1:0] tsel_q, sel_q;
   fault_e           res_cls;
   logic [SEL_W-1:0] res_err, res_ss;
   logic [AW-1:0]    res_sp;

   logic [AW-1:0]    ptr_off, sel_off;
   logic             tss_over;
   fault_t           sel_flt, stk_flt;

   isv_tss_locate #(.AW(AW)) u_locate (
      .dpl_i(dpl_q), .tss32_i(tss32_q), .limit_i(tlim_q),
      .ptr_off_o(ptr_off), .sel_off_o(sel_off), .over_o(tss_over)
   );

   isv_sel_check #(.AW(AW)) u_selchk (
      .sel_i(mem_rdata[SEL_W-1:0]), .code_dpl_i(dpl_q),
      .gdt_limit_i(glim_q), .ldt_limit_i(llim_q), .ext_i(ext_q),
      .flt_o(sel_flt)
   );

   isv_stack_check #(.AW(AW), .GRAN_EN(GRAN_EN)) u_stkchk (
      .desc_i(mem_rdata), .sel_i(sel_q), .code_dpl_i(dpl_q), .sp_i(sp_q),
      .gate32_i(gate32_q), .push_err_i(perr_q), .ext_i(ext_q),
      .flt_o(stk_flt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         dpl_q   <= '0;  tss32_q <= 1'b0; gate32_q <= 1'b0;
         perr_q  <= 1'b0; ext_q  <= 1'b0;
         tlim_q  <= '0;  glim_q <= '0; llim_q <= '0;
         cslim_q <= '0;  ip_q   <= '0; sp_q   <= '0;
         tsel_q  <= '0;  sel_q  <= '0;
         res_cls <= FC_NONE; res_err <= '0; res_ss <= '0; res_sp <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               dpl_q   <= tgt_dpl;   tss32_q <= tss32;    gate32_q <= gate32;
               perr_q  <= push_err;  ext_q   <= ext_evt;
               tlim_q  <= tss_limit; glim_q  <= gdt_limit; llim_q <= ldt_limit;
               cslim_q <= cs_limit;  ip_q    <= entry_ip;  tsel_q <= tss_sel;
               res_cls <= FC_NONE; res_err <= '0; res_ss <= '0; res_sp <= '0;
               state   <= ST_LOC;
            end
            ST_LOC: if (tss_over) begin
               res_cls <= FC_TASK;
               res_err <= {tsel_q[SEL_W-1:2], 1'b0, ext_q};
               state   <= ST_DONE;
            end else begin
               state   <= ST_PTR;
            end
            ST_PTR: if (mem_valid) begin
               sp_q  <= tss32_q ? AW'(mem_rdata[31:0]) : AW'(mem_rdata[15:0]);
               state <= ST_SEL;
            end
            ST_SEL: if (mem_valid) begin
               sel_q <= mem_rdata[SEL_W-1:0];
               if (sel_flt.cls != FC_NONE) begin
                  res_cls <= sel_flt.cls;
                  res_err <= sel_flt.err;
                  state   <= ST_DONE;
               end else begin
                  state   <= ST_DESC;
               end
            end
            ST_DESC: if (mem_valid) begin
               if (stk_flt.cls != FC_NONE) begin
                  res_cls <= stk_flt.cls;
                  res_err <= stk_flt.err;
               end else if (ip_q > cslim_q) begin
                  res_cls <= FC_PROT;
                  res_err <= '0;
               end else begin
                  res_ss  <= sel_q;
                  res_sp  <= sp_q;
               end
               state <= ST_DONE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_addr  = '0;
      mem_space = SP_TSS;
      case (state)
         ST_PTR:  mem_addr = ptr_off;
         ST_SEL:  mem_addr = sel_off;
         ST_DESC: begin
            mem_addr  = AW'({sel_q[SEL_W-1:3], 3'b000});
            mem_space = sel_q[2] ? SP_LDT : SP_GDT;
         end
         default: ;
      endcase
   end

   assign mem_req   = (state == ST_PTR) || (state == ST_SEL) || (state == ST_DESC);
   assign busy      = (state != ST_IDLE);
   assign done      = (state == ST_DONE);
   assign fault_cls = res_cls;
   assign err_code  = res_err;
   assign new_ss    = res_ss;
   assign new_sp    = res_sp;

   a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r12_busy_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);
   a_r13_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr) && $stable(mem_space)));
   a_r3_fetch_in_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_space == SP_TSS) |-> !tss_over);
   a_r9_gp_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault_cls == FC_PROT) |-> (err_code == '0));
   a_r14_ext_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (fault_cls == FC_TASK || fault_cls == FC_STACK)) |-> (err_code[0] == ext_q));
   a_r11_ok_result: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault_cls == FC_NONE) |-> (new_ss[15:2] != '0 && err_code == '0));
endmodule

// File: tb/istk_switch_validator_test.sv
`timescale 1ns/1ps
module istk_switch_validator_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  tgt_dpl = '0;
   logic        tss32 = 1'b0, gate32 = 1'b0, push_err = 1'b0, ext_evt = 1'b0;
   logic [31:0] tss_limit = '0, gdt_limit = '0, ldt_limit = '0, cs_limit = '0, entry_ip = '0;
   logic [15:0] tss_sel = '0;
   logic        mem_req, mem_valid = 1'b0;
   logic [1:0]  mem_space;
   logic [31:0] mem_addr;
   logic [63:0] mem_rdata = '0;
   logic        busy, done;
   logic [1:0]  fault_cls;
   logic [15:0] err_code, new_ss;
   logic [31:0] new_sp;

   int checks = 0, errors = 0;

   istk_switch_validator uut (
      .clk, .rst_n, .start, .tgt_dpl, .tss32, .tss_limit, .tss_sel, .gate32,
      .push_err, .ext_evt, .gdt_limit, .ldt_limit, .cs_limit, .entry_ip,
      .mem_req, .mem_space, .mem_addr, .mem_valid, .mem_rdata,
      .busy, .done, .fault_cls, .err_code, .new_ss, .new_sp
   );

   always #2.5 clk = ~clk;

   // scenario
   logic [1:0]  s_dpl;
   logic        s_tss32, s_gate32, s_perr, s_ext;
   logic [31:0] s_tlim, s_gdt, s_ldt, s_cslim, s_ip, s_ptr;
   logic [15:0] s_tsel, s_sel;
   logic [63:0] s_desc;
   int          s_lat;
   // expectation
   int          e_cls;
   logic [15:0] e_err, e_ss;
   logic [31:0] e_sp;
   logic [35:0] exp_q[$];
   int          lat_cnt = 0;

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] mk_desc(bit p, logic [1:0] dpl, logic [3:0] typ, bit s,
                                           logic [19:0] lim, bit g);
      logic [63:0] d = '0;
      d[15:0] = lim[15:0]; d[51:48] = lim[19:16];
      d[47] = p; d[46:45] = dpl; d[44] = s; d[43:40] = typ; d[55] = g;
      return d;
   endfunction

   task automatic defaults();
      s_dpl = 2'd0; s_tss32 = 1; s_gate32 = 1; s_perr = 1; s_ext = 0;
      s_tlim = 32'h67; s_tsel = 16'h0028; s_gdt = 32'hFF; s_ldt = 32'h3F;
      s_cslim = 32'hFFFF; s_ip = 32'h100; s_ptr = 32'h0000_8000; s_sel = 16'h0010;
      s_desc = mk_desc(1, 2'd0, 4'b0010, 1, 20'hFFFFF, 1); s_lat = 1;
   endtask

   task automatic model();
      logic [31:0] off, sp, lim, tl;
      int need;
      exp_q.delete();
      e_cls = 0; e_err = '0; e_ss = '0; e_sp = '0;
      off = s_tss32 ? s_dpl * 8 + 4 : s_dpl * 4 + 2;
      if (off + (s_tss32 ? 7 : 4) > s_tlim) begin
         e_cls = 1; e_err = {s_tsel[15:2], 1'b0, s_ext}; return;
      end
      exp_q.push_back({2'd0, 2'd0, off});
      exp_q.push_back({2'd1, 2'd0, off + (s_tss32 ? 32'd4 : 32'd2)});
      sp = s_tss32 ? s_ptr : {16'h0, s_ptr[15:0]};
      if (s_sel[15:2] == 0) begin e_cls = 1; e_err = {15'h0, s_ext}; return; end
      tl = s_sel[2] ? s_ldt : s_gdt;
      if ({16'h0, s_sel[15:3], 3'b111} > tl || s_sel[1:0] != s_dpl) begin
         e_cls = 1; e_err = {s_sel[15:2], 1'b0, s_ext}; return;
      end
      exp_q.push_back({2'd2, s_sel[2] ? 2'd2 : 2'd1, {16'h0, s_sel[15:3], 3'b000}});
      if (s_desc[46:45] != s_dpl || !(s_desc[44] && !s_desc[43] && s_desc[41])) begin
         e_cls = 1; e_err = {s_sel[15:2], 1'b0, s_ext}; return;
      end
      if (!s_desc[47]) begin e_cls = 2; e_err = {s_sel[15:2], 1'b0, s_ext}; return; end
      need = s_gate32 ? (s_perr ? 24 : 20) : (s_perr ? 12 : 10);
      lim = {12'h0, s_desc[51:48], s_desc[15:0]};
      if (s_desc[55]) lim = lim * 4096 + 4095;
      if (sp < need || sp - 1 > lim) begin
         e_cls = 2; e_err = {s_sel[15:2], 1'b0, s_ext}; return;
      end
      if (s_ip > s_cslim) begin e_cls = 3; e_err = '0; return; end
      e_ss = s_sel; e_sp = sp;
   endtask

   // memory responder
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_valid = 1'b0; lat_cnt = 0;
      end else if (mem_valid) begin
         mem_valid = 1'b0; lat_cnt = 0;
      end else if (mem_req) begin
         if (lat_cnt >= s_lat) begin
            if (exp_q.size() == 0) begin
               check(0, "R13 unexpected fetch", {30'h0, mem_space, mem_addr}, 64'h0);
               mem_rdata = '0;
            end else begin
               logic [35:0] e;
               e = exp_q.pop_front();
               check({mem_space, mem_addr} == e[33:0], "R1 R2 R13 fetch space/address",
                     {30'h0, mem_space, mem_addr}, {30'h0, e[33:0]});
               case (e[35:34])
                  2'd0:    mem_rdata = {32'hA5A5_5A5A, s_ptr};
                  2'd1:    mem_rdata = {48'hFFFF_FFFF_FFFF, s_sel};
                  default: mem_rdata = s_desc;
               endcase
            end
            mem_valid = 1'b1;
         end else begin
            lat_cnt++;
         end
      end
   end

   task automatic run_case(input string tag, input bit poke);
      bit got = 0;
      model();
      @(negedge clk);
      tgt_dpl = s_dpl; tss32 = s_tss32; tss_limit = s_tlim; tss_sel = s_tsel;
      gate32 = s_gate32; push_err = s_perr; ext_evt = s_ext; gdt_limit = s_gdt;
      ldt_limit = s_ldt; cs_limit = s_cslim; entry_ip = s_ip; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int n = 0; n < 300 && !got; n++) begin
         if (done) got = 1;
         else begin
            check(busy, {tag, " R12 busy in flight"}, busy, 1);
            if (poke && n == 1) begin start = 1'b1; tss32 = ~s_tss32; tgt_dpl = ~s_dpl; end
            if (poke && n == 2) begin start = 1'b0; tss32 = s_tss32; tgt_dpl = s_dpl; end
            @(negedge clk);
         end
      end
      check(got, {tag, " R12 done seen"}, got, 1);
      if (got) begin
         check(fault_cls == e_cls, {tag, " fault class"}, fault_cls, e_cls);
         check(err_code == e_err, {tag, " error code"}, err_code, e_err);
         check(new_ss == e_ss, {tag, " R11 new_ss"}, new_ss, e_ss);
         check(new_sp == e_sp, {tag, " R11 new_sp"}, new_sp, e_sp);
      end
      @(negedge clk);
      check(!done && !busy, {tag, " R12 one-cycle done"}, {done, busy}, 0);
      check(exp_q.size() == 0, {tag, " R13 all fetches made"}, exp_q.size(), 0);
   endtask

   initial begin
      #(5.0 * 200000);
      errors++;
      $display("FAIL watchdog expired, actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      defaults();
      repeat (3) @(negedge clk);
      check(!done && !busy && !mem_req, "R12 reset state", {done, busy, mem_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!done && !busy && !mem_req, "R12 idle after reset", {done, busy, mem_req}, 0);

      defaults(); run_case("R1 R11 32-bit pass dpl0", 0);
      defaults(); s_dpl = 3; s_sel = 16'h0013; s_desc = mk_desc(1, 3, 4'b0010, 1, 20'hFFFFF, 1);
      s_lat = 0; run_case("R1 32-bit dpl3", 0);
      defaults(); s_tss32 = 0; s_dpl = 2; s_tlim = 14; s_gate32 = 0; s_perr = 0;
      s_ptr = 32'hABCD_0040; s_sel = 16'h0012; s_desc = mk_desc(1, 2, 4'b0010, 1, 20'hFFFFF, 1);
      run_case("R2 R3 16-bit limit boundary pass", 0);
      s_tlim = 13; s_ext = 1; run_case("R3 R14 16-bit limit fault", 0);
      defaults(); s_dpl = 1; s_tlim = 18; run_case("R3 32-bit limit fault", 0);
      s_tlim = 19; s_sel = 16'h0009; s_desc = mk_desc(1, 1, 4'b0110, 1, 20'hFFFFF, 1);
      run_case("R1 R3 32-bit limit boundary pass", 0);
      defaults(); s_sel = 16'h0000; s_ext = 1; run_case("R4 R14 null selector", 0);
      defaults(); s_sel = 16'h0003; s_dpl = 1; run_case("R4 R10 null before rpl", 0);
      defaults(); s_sel = 16'h0100; run_case("R5 gdt index out of table", 0);
      defaults(); s_sel = 16'h0044; run_case("R5 ldt index out of table", 0);
      defaults(); s_sel = 16'h0034; s_lat = 2; run_case("R5 R13 ldt in table pass", 0);
      defaults(); s_sel = 16'h0011; run_case("R5 rpl mismatch", 0);
      defaults(); s_desc = mk_desc(1, 3, 4'b0010, 1, 20'hFFFFF, 1); run_case("R6 descriptor dpl", 0);
      defaults(); s_desc = mk_desc(1, 0, 4'b1010, 1, 20'hFFFFF, 1); run_case("R6 code segment", 0);
      defaults(); s_desc = mk_desc(0, 0, 4'b0000, 1, 20'hFFFFF, 1); run_case("R6 R10 read-only before present", 0);
      defaults(); s_desc = mk_desc(1, 0, 4'b0010, 0, 20'hFFFFF, 1); run_case("R6 system descriptor", 0);
      defaults(); s_desc = mk_desc(0, 0, 4'b0010, 1, 20'hFFFFF, 1); s_ext = 1;
      run_case("R7 R14 not present", 0);
      defaults(); s_ptr = 23; run_case("R8 room 32 err short", 0);
      defaults(); s_ptr = 24; run_case("R8 room 32 err exact", 0);
      defaults(); s_perr = 0; s_ptr = 20; run_case("R8 room 32 noerr exact", 0);
      defaults(); s_perr = 0; s_ptr = 19; run_case("R8 room 32 noerr short", 0);
      defaults(); s_gate32 = 0; s_ptr = 11; run_case("R8 room 16 err short", 0);
      defaults(); s_gate32 = 0; s_ptr = 12; run_case("R8 room 16 err exact", 0);
      defaults(); s_gate32 = 0; s_perr = 0; s_ptr = 9; run_case("R8 room 16 noerr short", 0);
      defaults(); s_desc = mk_desc(1, 0, 4'b0010, 1, 20'h00FFF, 0); s_ptr = 32'h1001;
      run_case("R8 byte limit exceeded", 0);
      s_ptr = 32'h1000; run_case("R8 byte limit top", 0);
      defaults(); s_desc = mk_desc(1, 0, 4'b0010, 1, 20'h00001, 1); s_ptr = 32'h2001;
      run_case("R8 scaled limit exceeded", 0);
      s_ptr = 32'h2000; run_case("R8 scaled limit top", 0);
      defaults(); s_ip = 32'h10000; run_case("R9 ip beyond limit", 0);
      s_ip = 32'hFFFF; run_case("R9 ip at limit", 0);
      defaults(); s_ip = 32'h10000; s_ptr = 23; run_case("R10 R8 room before ip", 0);
      defaults(); s_ip = 32'h10000; s_ptr = 3; s_sel = 16'h0011; run_case("R10 R5 rpl before later", 0);
      defaults(); s_lat = 3; s_dpl = 2; s_sel = 16'h0012;
      s_desc = mk_desc(1, 2, 4'b0010, 1, 20'hFFFFF, 1); run_case("R12 R13 start while busy", 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule